// File: doc/BRIEF.md
# ADC Conversion Tracking and Power Sequencer

This block runs the timing of one conversion for a successive-approximation ADC. A convert-start pulse opens a sequence with up to four phases. The first is an optional power-up wait. The second is an optional post-start tracking window. The third is a fixed settle of two system clocks after that window. The fourth is the SAR bit cycling, paced by a slower SAR clock enable. A one-cycle done pulse closes the sequence. The block drives three outputs: the analog power enable, the track (sample) enable and a strobe that marks the start of each SAR bit period.

A 2-bit mode field selects when tracking happens. With pre-tracking, the input is tracked while the block is idle. With post-tracking, tracking starts at the convert-start. Dual mode does both. The post-track window is 2, 4, 8 or 16 SAR periods, chosen by a 2-bit length code.

In burst mode with the enable bit clear, the converter stays unpowered while idle. On each start it powers up, then waits a programmable number of 200 ns units before it tracks or converts. The length of a 200 ns unit, counted in system clocks, is a parameter.

Top module: `adc_trk_seq`

## Requirements
- R1: With `burst` low, `pwr_en` equals `enable` in every cycle.
- R2: With `burst` and `enable` both high, `pwr_en` is high in every cycle.
- R3: With `burst` high and `enable` low, `pwr_en` is low while idle and high from the cycle after a convert-start until done. The sequence first waits (`pwr_cnt`+1)×`TICKS_PER_UNIT` system clocks before any tracking or conversion.
- R4: Mode code 2'b01 selects post-tracking, 2'b10 pre-tracking and 2'b11 dual tracking. The reserved code 2'b00 behaves exactly as 2'b01.
- R5: In post or dual mode, `trk_en` is high after the start (or after the power-up wait) for 2<<`post_len` SAR clock periods plus 2 system clocks. Conversion follows. `trk_en` and `bit_strobe` are never high together.
- R6: In pre or dual mode, `trk_en` is high while idle and powered, and during the power-up wait. In pre mode, conversion begins right after the start or after the power-up wait. There is no tracking during conversion.
- R7: Bit cycling issues exactly `SAR_BITS` `bit_strobe` pulses. Each pulse falls in a cycle where `sar_ce` is high.
- R8: `done` is a one-cycle pulse in the cycle after the last bit strobe.
- R9: A convert-start during a conversion is ignored. The running sequence keeps its length and no extra done follows.
- R10: While reset is held, with `burst` and `enable` low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sar_ce | input | 1 | One-cycle SAR clock enable, one pulse per SAR period |
| conv_start | input | 1 | Convert-start pulse |
| enable | input | 1 | Converter enable bit |
| burst | input | 1 | Burst (power-per-conversion) mode bit |
| trk_mode | input | 2 | Tracking mode: 01 post, 10 pre, 11 dual, 00 as post |
| post_len | input | 2 | Post-track length code: 2<<code SAR periods |
| pwr_cnt | input | 4 | Power-up wait in 200 ns units, minus one |
| pwr_en | output | 1 | Analog power enable |
| trk_en | output | 1 | Track (sample) enable |
| bit_strobe | output | 1 | Start-of-SAR-bit-period strobe |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest case to reach is a convert-start that lands in the middle of bit cycling. It has to arrive at a point the bench can only find by counting cycles from the accepted start. The bench runs a known post-track sequence and raises the start again at a fixed cycle offset inside the conversion phase. It then checks that the total latency is unchanged and that no second done appears. A second hard case is bit cycling with a divided SAR enable, where strobes must line up with enable pulses whatever the phase. The bench switches `sar_ce` to one pulse every three clocks and counts both the strobes and any strobes that fall outside an enable pulse.

// File: rtl/adc_trk_pkg.sv
package adc_trk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWRUP,
      ST_TRACK,
      ST_FIX,
      ST_CONV
   } seq_state_t;

   // tracking after the start: every code except pure pre-tracking
   function automatic logic mode_post(input logic [1:0] m);
      return m != 2'b10;
   endfunction

   // tracking before the start: pre and dual
   function automatic logic mode_pre(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/adc_trk_dcnt.sv
module adc_trk_dcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic         is_zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= ld_val;
      else if (dec && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign is_zero = (cnt == '0);
endmodule

// File: rtl/adc_trk_ctrl.sv
module adc_trk_ctrl
   import adc_trk_pkg::*;
#(
   parameter int TICKS_PER_UNIT = 10,
   parameter int SAR_BITS       = 12,
   parameter int FIX_CYC        = 2,
   parameter int WS             = 8,
   parameter int WR             = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sar_ce,
   input  logic          conv_start,
   input  logic          enable,
   input  logic          burst,
   input  logic [1:0]    trk_mode,
   input  logic [1:0]    post_len,
   input  logic [3:0]    pwr_cnt,
   input  logic          sys_zero,
   input  logic          sar_zero,
   output logic          sys_ld,
   output logic [WS-1:0] sys_val,
   output logic          sar_ld,
   output logic [WR-1:0] sar_val,
   output logic          pwr_en,
   output logic          trk_en,
   output logic          bit_strobe,
   output logic          done
);
   localparam logic [WR-1:0] BITS_M1 = WR'(SAR_BITS - 1);
   localparam logic [WS-1:0] FIX_M1  = WS'(FIX_CYC - 1);

   seq_state_t    state, nxt;
   logic          need_pwr, post, pre, fin;
   logic [WS-1:0] pwr_val;
   logic [WR-1:0] trk_val;

   assign need_pwr = burst & ~enable;
   assign post     = mode_post(trk_mode);
   assign pre      = mode_pre(trk_mode);
   assign pwr_val  = WS'((32'(pwr_cnt) + 32'd1) * 32'(TICKS_PER_UNIT) - 32'd1);
   assign trk_val  = WR'((32'd2 << post_len) - 32'd1);

   always_comb begin
      nxt     = state;
      sys_ld  = 1'b0;
      sys_val = '0;
      sar_ld  = 1'b0;
      sar_val = '0;
      fin     = 1'b0;
      case (state)
         ST_IDLE: begin
            if (conv_start) begin
               if (need_pwr) begin
                  nxt     = ST_PWRUP;
                  sys_ld  = 1'b1;
                  sys_val = pwr_val;
               end else if (post) begin
                  nxt     = ST_TRACK;
                  sar_ld  = 1'b1;
                  sar_val = trk_val;
               end else begin
                  nxt     = ST_CONV;
                  sar_ld  = 1'b1;
                  sar_val = BITS_M1;
               end
            end
         end
         ST_PWRUP: begin
            if (sys_zero) begin
               sar_ld = 1'b1;
               if (post) begin
                  nxt     = ST_TRACK;
                  sar_val = trk_val;
               end else begin
                  nxt     = ST_CONV;
                  sar_val = BITS_M1;
               end
            end
         end
         ST_TRACK: begin
            if (sar_ce && sar_zero) begin
               nxt     = ST_FIX;
               sys_ld  = 1'b1;
               sys_val = FIX_M1;
            end
         end
         ST_FIX: begin
            if (sys_zero) begin
               nxt     = ST_CONV;
               sar_ld  = 1'b1;
               sar_val = BITS_M1;
            end
         end
         ST_CONV: begin
            if (sar_ce && sar_zero) begin
               nxt = ST_IDLE;
               fin = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= fin;
      end
   end

   assign pwr_en     = burst ? (enable | (state != ST_IDLE)) : enable;
   assign trk_en     = (state == ST_TRACK) || (state == ST_FIX) ||
                       (pre && pwr_en && (state == ST_IDLE || state == ST_PWRUP));
   assign bit_strobe = (state == ST_CONV) && sar_ce;
endmodule

// File: rtl/adc_trk_seq.sv
module adc_trk_seq #(
   parameter int TICKS_PER_UNIT = 10,
   parameter int SAR_BITS       = 12,
   parameter int FIX_CYC        = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sar_ce,
   input  logic       conv_start,
   input  logic       enable,
   input  logic       burst,
   input  logic [1:0] trk_mode,
   input  logic [1:0] post_len,
   input  logic [3:0] pwr_cnt,
   output logic       pwr_en,
   output logic       trk_en,
   output logic       bit_strobe,
   output logic       done
);
   localparam int SYS_MAX = (16 * TICKS_PER_UNIT > FIX_CYC) ? 16 * TICKS_PER_UNIT : FIX_CYC;
   localparam int SAR_MAX = (SAR_BITS > 16) ? SAR_BITS : 16;
   localparam int WS      = $clog2(SYS_MAX + 1);
   localparam int WR      = $clog2(SAR_MAX + 1);

   generate
      if (TICKS_PER_UNIT < 1) begin : g_bad_ticks
         $error("TICKS_PER_UNIT must be at least 1");
      end
      if (SAR_BITS < 1) begin : g_bad_bits
         $error("SAR_BITS must be at least 1");
      end
      if (FIX_CYC < 1) begin : g_bad_fix
         $error("FIX_CYC must be at least 1");
      end
   endgenerate

   logic          sys_ld, sar_ld, sys_zero, sar_zero;
   logic [WS-1:0] sys_val;
   logic [WR-1:0] sar_val;

   adc_trk_dcnt #(.W(WS)) i_sys_cnt (
      .clk(clk), .rst_n(rst_n), .load(sys_ld), .ld_val(sys_val),
      .dec(1'b1), .is_zero(sys_zero)
   );

   adc_trk_dcnt #(.W(WR)) i_sar_cnt (
      .clk(clk), .rst_n(rst_n), .load(sar_ld), .ld_val(sar_val),
      .dec(sar_ce), .is_zero(sar_zero)
   );

   adc_trk_ctrl #(
      .TICKS_PER_UNIT(TICKS_PER_UNIT), .SAR_BITS(SAR_BITS),
      .FIX_CYC(FIX_CYC), .WS(WS), .WR(WR)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .conv_start(conv_start),
      .enable(enable), .burst(burst), .trk_mode(trk_mode),
      .post_len(post_len), .pwr_cnt(pwr_cnt),
      .sys_zero(sys_zero), .sar_zero(sar_zero),
      .sys_ld(sys_ld), .sys_val(sys_val), .sar_ld(sar_ld), .sar_val(sar_val),
      .pwr_en(pwr_en), .trk_en(trk_en), .bit_strobe(bit_strobe), .done(done)
   );
endmodule

// File: rtl/adc_trk_chk.sv
module adc_trk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sar_ce,
   input logic       enable,
   input logic       burst,
   input logic [1:0] trk_mode,
   input logic       pwr_en,
   input logic       trk_en,
   input logic       bit_strobe,
   input logic       done
);
   p_pwr_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !burst |-> (pwr_en == enable));

   p_pwr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (burst && enable) |-> pwr_en);

   p_no_trk_in_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trk_en |-> !bit_strobe);

   p_pre_no_trk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trk_mode == 2'b10 && bit_strobe) |-> !trk_en);

   p_strobe_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> sar_ce);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bit_strobe));
endmodule

bind adc_trk_seq adc_trk_chk i_chk (
   .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .enable(enable), .burst(burst),
   .trk_mode(trk_mode), .pwr_en(pwr_en), .trk_en(trk_en),
   .bit_strobe(bit_strobe), .done(done)
);

// File: tb/test_adc_trk_seq.sv
module test_adc_trk_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sar_div = 1'b0;
   logic [1:0] div = '0;
   logic       sar_ce;
   logic       conv_start = 1'b0;
   logic       enable = 1'b0;
   logic       burst = 1'b0;
   logic [1:0] trk_mode = 2'b01;
   logic [1:0] post_len = 2'd0;
   logic [3:0] pwr_cnt = 4'd0;
   logic       pwr_en, trk_en, bit_strobe, done;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;
   always @(negedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
   assign sar_ce = !sar_div || (div == 2'd0);

   adc_trk_seq #(.TICKS_PER_UNIT(4), .SAR_BITS(12), .FIX_CYC(2)) i_adc_trk_seq (
      .clk(clk), .rst_n(rst_n), .sar_ce(sar_ce), .conv_start(conv_start),
      .enable(enable), .burst(burst), .trk_mode(trk_mode),
      .post_len(post_len), .pwr_cnt(pwr_cnt), .pwr_en(pwr_en),
      .trk_en(trk_en), .bit_strobe(bit_strobe), .done(done)
   );

   // {burst, enable, mode[1:0], post_len[1:0], pwr_cnt[3:0], latency, trk cycles, pwr cycles}
   // with sar_ce always high, TICKS_PER_UNIT=4, SAR_BITS=12
   localparam logic [33:0] TBL [0:10] = '{
      {1'b0, 1'b1, 2'b01, 2'd0, 4'd0,  8'd17, 8'd4,  8'd16},
      {1'b0, 1'b1, 2'b01, 2'd3, 4'd5,  8'd31, 8'd18, 8'd30},
      {1'b0, 1'b1, 2'b10, 2'd2, 4'd0,  8'd13, 8'd0,  8'd12},
      {1'b0, 1'b1, 2'b11, 2'd1, 4'd0,  8'd19, 8'd6,  8'd18},
      {1'b0, 1'b1, 2'b00, 2'd1, 4'd0,  8'd19, 8'd6,  8'd18},
      {1'b1, 1'b0, 2'b01, 2'd0, 4'd0,  8'd21, 8'd4,  8'd20},
      {1'b1, 1'b0, 2'b01, 2'd2, 4'd15, 8'd87, 8'd10, 8'd86},
      {1'b1, 1'b0, 2'b10, 2'd0, 4'd3,  8'd29, 8'd16, 8'd28},
      {1'b1, 1'b0, 2'b11, 2'd3, 4'd1,  8'd39, 8'd26, 8'd38},
      {1'b1, 1'b1, 2'b01, 2'd1, 4'd7,  8'd19, 8'd6,  8'd18},
      {1'b0, 1'b0, 2'b01, 2'd0, 4'd0,  8'd17, 8'd4,  8'd0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // pulse a start at the current negedge; count per cycle until done
   task automatic run_conv(input int extra_at, output int lat, output int trk,
                           output int pw, output int stb, output int stb_bad);
      int k;
      trk = 0; pw = 0; stb = 0; stb_bad = 0;
      conv_start = 1'b1;
      @(negedge clk);
      k = 1;
      while (!done && k < 400) begin
         if (trk_en) trk++;
         if (pwr_en) pw++;
         if (bit_strobe) begin
            stb++;
            if (!sar_ce) stb_bad++;
         end
         conv_start = (k == extra_at);
         @(negedge clk);
         k++;
      end
      conv_start = 1'b0;
      lat = k;
   endtask

   initial begin
      #2_000_000;
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int lat, trk, pw, stb, sbad, extra_done;
      logic [33:0] row;

      // R10: outputs during reset
      repeat (3) @(negedge clk);
      chk("R10 reset pwr_en", pwr_en, 0);
      chk("R10 reset trk_en", trk_en, 0);
      chk("R10 reset bit_strobe", bit_strobe, 0);
      chk("R10 reset done", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 11; i++) begin
         row      = TBL[i];
         burst    = row[33];
         enable   = row[32];
         trk_mode = row[31:30];
         post_len = row[29:28];
         pwr_cnt  = row[27:24];
         repeat (3) @(negedge clk);
         chk("R1,R2,R3 idle pwr_en", pwr_en, int'(row[32]));
         chk("R6 idle trk_en", trk_en, int'(row[31] & row[32]));
         run_conv(0, lat, trk, pw, stb, sbad);
         chk("R3,R4,R5,R6 latency", lat, int'(row[23:16]));
         chk("R5,R6 trk cycles", trk, int'(row[15:8]));
         chk("R1,R2,R3 pwr cycles", pw, int'(row[7:0]));
         chk("R7 strobe count", stb, 12);
         @(negedge clk);
         chk("R8 done one cycle", done, 0);
      end

      // R9: start raised again in the middle of bit cycling
      burst = 1'b0; enable = 1'b1; trk_mode = 2'b01; post_len = 2'd0; pwr_cnt = 4'd0;
      repeat (3) @(negedge clk);
      run_conv(10, lat, trk, pw, stb, sbad);
      chk("R9 latency with extra start", lat, 17);
      chk("R9 strobes with extra start", stb, 12);
      extra_done = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (done) extra_done++;
      end
      chk("R9 no extra done", extra_done, 0);

      // R7: divided SAR enable, pre-tracking
      sar_div = 1'b1; trk_mode = 2'b10;
      repeat (4) @(negedge clk);
      run_conv(0, lat, trk, pw, stb, sbad);
      chk("R7 divided strobe count", stb, 12);
      chk("R7 strobes off sar_ce", sbad, 0);
      chk("R6 no tracking in pre conversion", trk, 0);
      @(negedge clk);
      chk("R8 done one cycle divided", done, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule